// File: doc/BRIEF.md
# Serial Converter Result Shifter with Cascade

This block is the serial output port of a 16-bit data converter. The host supplies the serial clock. The block moves each conversion result out one bit per serial clock pulse, most significant bit first. It is clocked by a fast system clock. The host's serial clock, chip-select, read-enable, the busy flag and the cascade input each pass through a two-flop synchronizer. The block then acts on the edges it detects in those synchronized signals. The bench provides the conversion result and the busy timing.

There are two operating modes. In read-after-conversion mode, the result becomes readable once busy falls. Several devices can be chained in this mode: this device shifts in bits from an upstream device on its cascade input, and those bits follow its own word with no gap. In read-during-conversion mode, the host reads the previous result while the next conversion is running. The cascade input is ignored in this mode. If a read has started but is not complete when busy falls, a one-cycle read-error pulse is raised.

Top module: `adc_serial_shifter`

## Requirements
- R1: The shift register neither shifts nor samples the cascade input unless chip-select (`cs_n`) and read-enable (`rd_n`) are both low. Serial clock pulses outside that window leave `sdo` unchanged.
- R2: A result is sent as 16 bits, most significant bit first. `sdo` advances one bit after each serial clock falling edge. The host samples on rising edges, so rising edge k presents bit 16-k of the word.
- R3: On every falling edge of `busy`, the block captures `result_in`, and its bit 15 appears on `sdo` without any serial clock pulse.
- R4: In read-after mode (`mode_during` = 0), `casc_in` is sampled on each serial clock rising edge. Rising edges 17 to 32 present the bits that were sampled on rising edges 1 to 16, in the same order. With an upstream device, its MSB therefore directly follows this device's LSB.
- R5: In read-during mode (`mode_during` = 1), the previously captured result can be read in full while `busy` is high. If all 16 rising edges occur before `busy` falls, no read error is raised.
- R6: In read-during mode, if between 1 and 15 rising edges have been counted since the last capture when `busy` falls, `rd_err` is high for exactly one system clock cycle.
- R7: In read-during mode `casc_in` is ignored. Every bit presented after the 16th is 0, whatever the level of `casc_in`.
- R8: In read-after mode `rd_err` never goes high, whether reads are complete or not.
- R9: After reset, `sdo` and `rd_err` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| result_in | input | 16 | Conversion result, captured on busy falling edge |
| busy | input | 1 | High while a conversion is running |
| cs_n | input | 1 | Active-low chip-select |
| rd_n | input | 1 | Active-low read-enable |
| sclk | input | 1 | Host serial clock, idles low |
| mode_during | input | 1 | 0: read after conversion, 1: read during conversion |
| casc_in | input | 1 | Serial data from upstream device |
| sdo | output | 1 | Serial data out |
| rd_err | output | 1 | One-cycle pulse on an incomplete read-during read |

## Verification
The bench tries several input patterns:
- Random result and upstream word pairs read as a 32-bit chained stream in read-after mode. These distinguish bit order, the alignment at the seam between the two words, and any slip of one bit in cascade sampling.
- Serial clock pulses with read-enable high, placed before a normal read. These separate gated shifting from free-running shifting.
- Random full reads in read-during mode with `casc_in` forced high. These show that the cascade path is shut off in that mode and that complete reads raise no error.
- A partial read in each mode. This pins down the error pulse's width and shows that it depends on the mode.

// File: rtl/adc_serial_shifter.sv
module adc_serial_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] result_in,
  input  logic             busy,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             sclk,
  input  logic             mode_during,
  input  logic             casc_in,
  output logic             sdo,
  output logic             rd_err
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] FULL = CW'(WIDTH);

  logic [2:0] sclk_s, busy_s;
  logic [1:0] cs_s, rd_s, casc_s;
  logic [WIDTH:0] sr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      busy_s <= '0;
      cs_s   <= '1;
      rd_s   <= '1;
      casc_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      busy_s <= {busy_s[1:0], busy};
      cs_s   <= {cs_s[0], cs_n};
      rd_s   <= {rd_s[0], rd_n};
      casc_s <= {casc_s[0], casc_in};
    end
  end

  wire sel       = ~cs_s[1] & ~rd_s[1];
  wire sck_rise  = sclk_s[1] & ~sclk_s[2];
  wire sck_fall  = ~sclk_s[1] & sclk_s[2];
  wire busy_fall = ~busy_s[1] & busy_s[2];
  wire partial   = (cnt != '0) && (cnt < FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      cnt    <= '0;
      rd_err <= 1'b0;
    end else if (busy_fall) begin
      sr     <= {result_in, 1'b0};
      cnt    <= '0;
      rd_err <= mode_during & partial;
    end else begin
      rd_err <= 1'b0;
      if (cs_s[1]) cnt <= '0;
      if (sel && sck_rise) begin
        sr[0] <= mode_during ? 1'b0 : casc_s[1];
        if (cnt != FULL) cnt <= cnt + CW'(1);
      end else if (sel && sck_fall) begin
        sr <= {sr[WIDTH-1:0], 1'b0};
      end
    end
  end

  assign sdo = sr[WIDTH];

  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !busy_fall) |=> $stable(sdo)); // R1
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL); // R2
  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    busy_fall |=> (sdo == $past(result_in[WIDTH-1]))); // R3
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> !rd_err); // R6
  AST_ERR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(mode_during)); // R8
endmodule

// File: tb/adc_serial_shifter_bench.sv
module adc_serial_shifter_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] result_in = '0;
  logic busy = 0, cs_n = 1, rd_n = 1, sclk = 0, mode_during = 0, casc_in = 0;
  logic sdo, rd_err;
  int checks = 0, failures = 0, err_pulses = 0, err_long = 0;
  logic err_prev = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_serial_shifter u_adc_serial_shifter (
    .clk(clk), .rst_n(rst_n), .result_in(result_in), .busy(busy),
    .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk), .mode_during(mode_during),
    .casc_in(casc_in), .sdo(sdo), .rd_err(rd_err));

  always @(posedge clk) begin
    if (rd_err) err_pulses <= err_pulses + 1;
    if (rd_err && err_prev) err_long <= err_long + 1;
    err_prev <= rd_err;
  end

  function automatic logic [31:0] chain_word(logic [15:0] own, logic [15:0] up);
    return {own, up};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_bit(input logic c, output logic b);
    casc_in = c;
    b = sdo;
    sclk = 1'b1;
    wait_clk(6);
    sclk = 1'b0;
    wait_clk(6);
  endtask

  task automatic load(input logic [15:0] w);
    result_in = w;
    busy = 1'b1;
    wait_clk(8);
    busy = 1'b0;
    wait_clk(8);
  endtask

  task automatic read_chain(input logic [15:0] up, output logic [31:0] got);
    logic b;
    got = '0;
    cs_n = 0; rd_n = 0; wait_clk(4);
    for (int k = 0; k < 32; k++) begin
      rd_bit((k < 16) ? up[15-k] : 1'b0, b);
      got = {got[30:0], b};
    end
    cs_n = 1; rd_n = 1; wait_clk(4);
  endtask

  initial begin
    logic [31:0] got;
    logic [15:0] w, u, w1;
    logic b;
    int e0;
    void'($urandom(32'h5EED));
    wait_clk(3);
    check("R9 sdo after reset", {31'd0, sdo}, 32'd0);
    check("R9 rd_err after reset", {31'd0, rd_err}, 32'd0);
    rst_n = 1'b1;
    wait_clk(4);

    // R2 R3 R4 directed chain
    load(16'hA5C3);
    check("R3 msb visible after capture", {31'd0, sdo}, 32'd1);
    read_chain(16'h3C5A, got);
    check("R4 directed chained stream", got, chain_word(16'hA5C3, 16'h3C5A));

    // R2 R4 random chains
    for (int i = 0; i < 20; i++) begin
      w = 16'($urandom); u = 16'($urandom);
      load(w);
      read_chain(u, got);
      check("R2/R4 random chained stream", got, chain_word(w, u));
    end

    // R1 gating by read-enable
    load(16'h8001);
    cs_n = 0; rd_n = 1; wait_clk(4);
    for (int k = 0; k < 3; k++) begin
      rd_bit(1'b1, b);
      check("R1 sdo held while unselected", {31'd0, sdo}, 32'd1);
    end
    cs_n = 1; wait_clk(4);
    read_chain(16'h0000, got);
    check("R1 full word after unselected pulses", got, chain_word(16'h8001, 16'h0000));

    // R8 partial read in read-after mode
    e0 = err_pulses;
    load(16'h1234);
    cs_n = 0; rd_n = 0; wait_clk(4);
    for (int k = 0; k < 5; k++) rd_bit(1'b0, b);
    load(16'h4321);
    cs_n = 1; rd_n = 1; wait_clk(4);
    check("R8 no error in read-after mode", 32'(err_pulses - e0), 32'd0);

    // R5 R7 read-during full reads
    mode_during = 1'b1;
    w = 16'($urandom);
    load(w);
    for (int i = 0; i < 8; i++) begin
      w1 = 16'($urandom);
      e0 = err_pulses;
      busy = 1'b1; wait_clk(8);
      got = '0;
      cs_n = 0; rd_n = 0; wait_clk(4);
      for (int k = 0; k < 17; k++) begin
        rd_bit(1'b1, b);
        if (k < 16) got = {got[30:0], b};
        else check("R7 bit after 16th is zero", {31'd0, b}, 32'd0);
      end
      check("R5 word read during conversion", got, {16'd0, w});
      result_in = w1;
      busy = 1'b0; wait_clk(8);
      cs_n = 1; rd_n = 1; wait_clk(4);
      check("R5 no error on complete read", 32'(err_pulses - e0), 32'd0);
      w = w1;
    end

    // R6 partial read in read-during mode
    e0 = err_pulses;
    busy = 1'b1; wait_clk(8);
    cs_n = 0; rd_n = 0; wait_clk(4);
    got = '0;
    for (int k = 0; k < 5; k++) begin
      rd_bit(1'b0, b);
      got = {got[30:0], b};
    end
    check("R6 partial bits correct", got, {27'd0, w[15:11]});
    result_in = 16'hBEEF;
    busy = 1'b0; wait_clk(8);
    cs_n = 1; rd_n = 1; wait_clk(4);
    check("R6 one error pulse", 32'(err_pulses - e0), 32'd1);
    check("R6 pulse width one cycle", 32'(err_long), 32'd0);
    check("R3 new word msb after busy fall", {31'd0, sdo}, 32'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule